// File: doc/BRIEF.md
# Byte FIFO with Occupancy Count and Threshold Interrupt

This block is a 64-entry byte queue for one direction of a serial port. A producer pushes bytes and a consumer pops them; the oldest byte is always visible on the read data port. The block reports how many bytes it holds as an 8-bit count, and it raises full and empty flags.

Software programs a byte-granular threshold between 0 and 64. The block compares that threshold against the live count to drive an interrupt. A build-time parameter picks the sense of the comparison. The transmit-side copy interrupts while the queue holds fewer bytes than the threshold, which asks for a refill. The receive-side copy interrupts once the queue holds at least the threshold, which asks for a drain. Attempts to push into a full queue or pop from an empty one are dropped, and each kind is recorded in its own sticky flag.

Top module: `level_fifo`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0), `level` is 0, the threshold is 0, and `overflow` and `underflow` are 0.
- R2: Bytes leave in the order they entered. `level` counts the stored bytes from 0 to 64. `full` is 1 exactly at 64 and `empty` is 1 exactly at 0. `pop_data` shows the oldest stored byte.
- R3: A push while `full` is 1 stores nothing and leaves the stored bytes unchanged. It sets `overflow`, which then stays 1 until reset.
- R4: A pop while `empty` is 1 removes nothing. It sets `underflow`, which then stays 1 until reset.
- R5: When a push and a pop are both accepted in the same cycle, `level` is unchanged. When only one of the two is accepted, `level` changes by one in that direction.
- R6: A threshold write (`trig_wr`=1) takes effect on the next cycle. A value above 64 is stored as 64.
- R7: With `TRIG_SENSE` = SENSE_BELOW (encoding 0, transmit use), `irq` is 1 while `level` < threshold and `irq_en` is 1.
- R8: With `TRIG_SENSE` = SENSE_AT_OR_ABOVE (encoding 1, receive use, the default), `irq` is 1 while `level` >= threshold and `irq_en` is 1.
- R9: `irq` is 0 whenever `irq_en` is 0. Otherwise `irq` follows the registered `level` and threshold in the same cycle, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| push | input | 1 | Store `push_data` this cycle |
| push_data | input | 8 | Byte to store |
| pop | input | 1 | Remove the oldest byte this cycle |
| pop_data | output | 8 | Oldest stored byte |
| trig_wr | input | 1 | Load a new threshold |
| trig_val | input | 8 | Threshold value, clamped to 64 |
| irq_en | input | 1 | Interrupt enable |
| level | output | 8 | Number of stored bytes |
| full | output | 1 | Queue holds 64 bytes |
| empty | output | 1 | Queue holds no bytes |
| overflow | output | 1 | Sticky: a push was dropped |
| underflow | output | 1 | Sticky: a pop was dropped |
| irq | output | 1 | Threshold interrupt |

## Verification
A push or pop sampled at a clock edge changes `level`, `full`, `empty`, `pop_data` and the sticky flags right after that edge, so each of these is due one cycle after its stimulus. A threshold write is also visible one cycle later. `irq` settles in the same cycle as the count it depends on, and a change on `irq_en` shows on `irq` without waiting for a clock. The bench applies each stimulus for exactly one edge and reads every output a quarter period after that edge, before the next stimulus is applied. It drives a receive-sense and a transmit-sense instance with the same inputs so that both comparison senses are checked on every step.

// File: rtl/level_fifo_pkg.sv
package level_fifo_pkg;
  typedef enum logic {
    SENSE_BELOW       = 1'b0,
    SENSE_AT_OR_ABOVE = 1'b1
  } trig_sense_e;
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, wr_ptr_nxt;
  logic [PTR_W-1:0]  rd_ptr, rd_ptr_nxt;

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    if (wr_en) wr_ptr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    if (rd_en) rd_ptr_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/fifo_level.sv
module fifo_level #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             ovf,
  output logic             udf
);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count_nxt;
  logic             ovf_nxt, udf_nxt;

  assign full  = (count == MAXC);
  assign empty = (count == '0);
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;

  always_comb begin
    count_nxt = count;
    if (wr_ok && !rd_ok) count_nxt = count + 1'b1;
    if (rd_ok && !wr_ok) count_nxt = count - 1'b1;
    ovf_nxt = ovf | (push && full);
    udf_nxt = udf | (pop && empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
      udf   <= 1'b0;
    end else begin
      count <= count_nxt;
      ovf   <= ovf_nxt;
      udf   <= udf_nxt;
    end
  end

  assert_level_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= MAXC);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == MAXC) && ovf);
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0) && udf);
  assert_udf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    udf |=> udf);
  assert_both_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> $stable(count));
endmodule

// File: rtl/fifo_trigger.sv
module fifo_trigger
  import level_fifo_pkg::*;
#(
  parameter int          DEPTH = 64,
  parameter int          CNT_W = 8,
  parameter trig_sense_e SENSE = SENSE_AT_OR_ABOVE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] val,
  input  logic             en,
  input  logic [CNT_W-1:0] count,
  output logic             irq
);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(DEPTH);

  logic [CNT_W-1:0] thr, thr_nxt;
  logic             hit;

  always_comb begin
    thr_nxt = thr;
    if (wr) thr_nxt = (val > MAXC) ? MAXC : val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr <= '0;
    else        thr <= thr_nxt;
  end

  generate
    if (SENSE == SENSE_BELOW) begin : g_below
      assign hit = (count < thr);
    end else begin : g_at_or_above
      assign hit = (count >= thr);
    end
  endgenerate

  assign irq = en && hit;

  assert_thr_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    thr <= MAXC);
  assert_thr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && val <= MAXC) |=> (thr == $past(val)));
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);
endmodule

// File: rtl/level_fifo.sv
module level_fifo
  import level_fifo_pkg::*;
#(
  parameter int          DEPTH      = 64,
  parameter int          DATA_W     = 8,
  parameter int          CNT_W      = 8,
  parameter trig_sense_e TRIG_SENSE = SENSE_AT_OR_ABOVE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  input  logic              trig_wr,
  input  logic [CNT_W-1:0]  trig_val,
  input  logic              irq_en,
  output logic [CNT_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic              overflow,
  output logic              underflow,
  output logic              irq
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       wr_ok, rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  fifo_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
    .clk(clk), .rst_n(rst_int_n), .push(push), .pop(pop),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .count(level), .full(full),
    .empty(empty), .ovf(overflow), .udf(underflow)
  );

  fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_ok), .wr_data(push_data),
    .rd_en(rd_ok), .rd_data(pop_data)
  );

  fifo_trigger #(.DEPTH(DEPTH), .CNT_W(CNT_W), .SENSE(TRIG_SENSE)) u_trig (
    .clk(clk), .rst_n(rst_int_n), .wr(trig_wr), .val(trig_val),
    .en(irq_en), .count(level), .irq(irq)
  );

  assert_flags_excl_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(full && empty));
endmodule

// File: tb/test_level_fifo.sv
module test_level_fifo;
  import level_fifo_pkg::*;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       psh;
    logic       pp;
    logic [7:0] din;
    logic       twr;
    logic [7:0] tval;
    logic [7:0] lvl;
    logic [7:0] head;
    logic       irx;
    logic       itx;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'd3,   8'd0, 8'h00, 1'b0, 1'b1},
    '{1'b1, 1'b0, 8'hA1, 1'b0, 8'd0,   8'd1, 8'hA1, 1'b0, 1'b1},
    '{1'b1, 1'b0, 8'hA2, 1'b0, 8'd0,   8'd2, 8'hA1, 1'b0, 1'b1},
    '{1'b1, 1'b1, 8'hA3, 1'b0, 8'd0,   8'd2, 8'hA2, 1'b0, 1'b1},
    '{1'b1, 1'b0, 8'hA4, 1'b0, 8'd0,   8'd3, 8'hA2, 1'b1, 1'b0},
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'd200, 8'd3, 8'hA2, 1'b0, 1'b1},
    '{1'b0, 1'b1, 8'h00, 1'b0, 8'd0,   8'd2, 8'hA3, 1'b0, 1'b1},
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'd2,   8'd2, 8'hA3, 1'b1, 1'b0},
    '{1'b0, 1'b1, 8'h00, 1'b0, 8'd0,   8'd1, 8'hA4, 1'b0, 1'b1},
    '{1'b0, 1'b1, 8'h00, 1'b0, 8'd0,   8'd0, 8'h00, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n, push, pop, trig_wr, irq_en;
  logic [7:0] push_data, trig_val;
  logic [7:0] pop_data, level, pop_data_tx, level_tx;
  logic       full, empty, overflow, underflow, irq;
  logic       full_tx, empty_tx, ovf_tx, udf_tx, irq_tx;
  int         n_checks = 0;
  int         n_fail   = 0;
  bit         done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  level_fifo #(.TRIG_SENSE(SENSE_AT_OR_ABOVE)) i_level_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data), .trig_wr(trig_wr), .trig_val(trig_val), .irq_en(irq_en),
    .level(level), .full(full), .empty(empty), .overflow(overflow),
    .underflow(underflow), .irq(irq)
  );

  level_fifo #(.TRIG_SENSE(SENSE_BELOW)) i_level_fifo_tx (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data_tx), .trig_wr(trig_wr), .trig_val(trig_val), .irq_en(irq_en),
    .level(level_tx), .full(full_tx), .empty(empty_tx), .overflow(ovf_tx),
    .underflow(udf_tx), .irq(irq_tx)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle(input logic p, input logic q, input logic [7:0] d,
                       input logic tw, input logic [7:0] tv);
    push = p; pop = q; push_data = d; trig_wr = tw; trig_val = tv;
    @(posedge clk);
    #(CLK_PERIOD/4);
    push = 1'b0; pop = 1'b0; trig_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; push = 1'b0; pop = 1'b0; trig_wr = 1'b0;
    push_data = '0; trig_val = '0; irq_en = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);

    // R1 reset state; threshold 0 shows as R8 irq on receive side
    check("R1 level", level, 0);
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 overflow", overflow, 0);
    check("R1 underflow", underflow, 0);
    check("R8 rx irq at thr 0", irq, 1);
    check("R7 tx irq at thr 0", irq_tx, 0);

    // table walk: R2 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      cycle(VECS[i].psh, VECS[i].pp, VECS[i].din, VECS[i].twr, VECS[i].tval);
      check("R2/R5 level", level, VECS[i].lvl);
      if (VECS[i].lvl != 0) check("R2 head", pop_data, VECS[i].head);
      check("R8/R6 rx irq", irq, VECS[i].irx);
      check("R7/R6 tx irq", irq_tx, VECS[i].itx);
    end

    // fill to 64 with threshold 64 (R6 upper bound)
    cycle(1'b0, 1'b0, 8'h00, 1'b1, 8'd64);
    check("R7 tx irq level0 thr64", irq_tx, 1);
    for (int k = 0; k < 64; k++) begin
      cycle(1'b1, 1'b0, 8'(8'h40 + k), 1'b0, 8'd0);
      if (k == 62) begin
        check("R8 rx irq level63 thr64", irq, 0);
        check("R2 full at 63", full, 0);
      end
    end
    check("R2 level 64", level, 64);
    check("R2 full", full, 1);
    check("R8 rx irq level64 thr64", irq, 1);
    check("R7 tx irq level64 thr64", irq_tx, 0);

    // R3 push into full
    cycle(1'b1, 1'b0, 8'hEE, 1'b0, 8'd0);
    check("R3 level kept", level, 64);
    check("R3 overflow", overflow, 1);
    check("R3 head kept", pop_data, 8'h40);

    // push+pop while full: only pop accepted (R5)
    cycle(1'b1, 1'b1, 8'hEF, 1'b0, 8'd0);
    check("R5 level full both", level, 63);
    check("R5 head", pop_data, 8'h41);
    check("R7 tx irq level63", irq_tx, 1);

    // drain, checking order (R2)
    for (int k = 0; k < 63; k++) begin
      check("R2 drain order", pop_data, 8'(8'h41 + k));
      cycle(1'b0, 1'b1, 8'h00, 1'b0, 8'd0);
    end
    check("R2 empty after drain", empty, 1);
    check("R3 overflow sticky", overflow, 1);
    check("R4 underflow clear", underflow, 0);

    // R4 pop from empty
    cycle(1'b0, 1'b1, 8'h00, 1'b0, 8'd0);
    check("R4 level kept", level, 0);
    check("R4 underflow", underflow, 1);

    // push+pop while empty: only push accepted (R5)
    cycle(1'b1, 1'b1, 8'h99, 1'b0, 8'd0);
    check("R5 level empty both", level, 1);
    check("R5 head stored", pop_data, 8'h99);
    check("R4 underflow sticky", underflow, 1);

    // R9 enable gating, combinational
    check("R9 tx irq enabled", irq_tx, 1);
    irq_en = 1'b0;
    #1;
    check("R9 tx irq gated", irq_tx, 0);
    check("R9 rx irq gated", irq, 0);
    cycle(1'b0, 1'b0, 8'h00, 1'b1, 8'd0);
    check("R9 rx irq gated thr0", irq, 0);
    irq_en = 1'b1;
    #1;
    check("R9 rx irq reenabled", irq, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule